// File: doc/BRIEF.md
# Parallel Bit Deposit Unit

This execution unit spreads the low-order bits of a source word across a wider word. A mask word selects the destination positions: walking the mask from its least significant bit upward, each set bit receives the next unused source bit, starting at source bit 0. Every position whose mask bit is clear comes out as zero. The unit has one registered output stage, so a result appears one clock after its operands.

Two operand sizes exist, 32 and 64 bits. The wide size is used only when the size-select input and the 64-bit-mode indicator are both high. In the narrow size only the low 32 mask and source bits take part, and the upper half of the result is zero, as a 32-bit register write would leave it. A set vector-length bit makes the request illegal. In that case the unit raises an illegal flag instead of a result and leaves the held result untouched. No status flags are produced.

Top module: `bit_deposit_unit`

## Requirements
- R1: For every set mask bit at position m, result bit m equals source bit k, where k is the number of set mask bits below position m in the effective mask.
- R2: Every result bit whose effective mask bit is clear is zero.
- R3: An all-ones effective mask returns the source unchanged, and a zero mask returns zero.
- R4: In the narrow size (32 bits), mask bits 63:32 and source bits 63:32 have no effect, and result bits 63:32 are zero.
- R5: The wide size (64 bits) is used only when in_wide=1 and in_long_mode=1. With in_long_mode=0, in_wide is ignored and the narrow size applies.
- R6: A request with in_valid=1 and in_vlen=1 raises out_illegal one cycle later with out_valid=0, and out_result keeps its previous value.
- R7: A legal request (in_valid=1, in_vlen=0) raises out_valid exactly one cycle later. A cycle with in_valid=0 is followed by out_valid=0 and out_illegal=0.
- R8: out_result changes only in cycles where out_valid is 1 and otherwise holds its value.
- R9: While rst_n is 0, out_valid, out_illegal and out_result are all zero.
- R10: A mask with only bits 2, 5, 7 and 9 set and source bits 3:0 = 4'b1011 gives the result 64'h224.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are present this cycle |
| in_src | input | 64 | Source bits, consumed from bit 0 upward |
| in_mask | input | 64 | Deposit mask |
| in_wide | input | 1 | Requests the 64-bit operand size |
| in_long_mode | input | 1 | 64-bit mode indicator; gates in_wide |
| in_vlen | input | 1 | Vector-length field bit; must be 0 |
| out_valid | output | 1 | Result is valid this cycle |
| out_result | output | 64 | Deposited result, held between valid cycles |
| out_illegal | output | 1 | Previous request was illegal |

## Verification
Two decisions are made in the same cycle: the size is resolved from the size select and the mode indicator, and the vector-length bit is checked for legality. The bench drives requests that set all three of in_wide, in_long_mode and in_vlen together. It checks that the illegal flag wins, that no valid pulse appears, and that the held result is not overwritten by a wide-size result. It also issues back-to-back requests of alternating sizes, with upper mask and source bits filled with junk. A behavioural loop model, updated each clock, then confirms that each result follows the size of its own request and not the size of the request before it.

// File: rtl/pdep_pkg.sv
`timescale 1ns/1ps
package pdep_pkg;

   // Operand size after mode qualification
   typedef enum logic {
      SZ_NARROW = 1'b0,
      SZ_WIDE   = 1'b1
   } opsize_e;

   // Decoded request control
   typedef struct packed {
      logic    illegal;
      opsize_e size;
   } opctl_t;

   // Prefix-count implementation variants
   localparam int unsigned RANK_RIPPLE = 0;
   localparam int unsigned RANK_LOG    = 1;

endpackage

// File: rtl/pdep_op_ctl.sv
`timescale 1ns/1ps
module pdep_op_ctl
   import pdep_pkg::*;
(
   input  logic   wide_req,
   input  logic   long_mode,
   input  logic   vlen_bit,
   output opctl_t ctl
);

   always_comb begin
      ctl.illegal = vlen_bit;
      ctl.size    = (wide_req && long_mode) ? SZ_WIDE : SZ_NARROW;
   end

endmodule

// File: rtl/pdep_mask_shape.sv
`timescale 1ns/1ps
module pdep_mask_shape #(
   parameter int unsigned WORD_W   = 64,
   parameter int unsigned NARROW_W = 32
) (
   input  logic              wide,
   input  logic [WORD_W-1:0] mask_i,
   output logic [WORD_W-1:0] mask_o
);

   // Bits above the narrow width survive only in the wide size
   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      if (i < NARROW_W) begin : g_low
         assign mask_o[i] = mask_i[i];
      end else begin : g_high
         assign mask_o[i] = mask_i[i] & wide;
      end
   end

endmodule

// File: rtl/pdep_rank.sv
`timescale 1ns/1ps
module pdep_rank
   import pdep_pkg::*;
#(
   parameter int unsigned WORD_W     = 64,
   parameter int unsigned RANK_STYLE = RANK_LOG
) (
   input  logic [WORD_W-1:0]                      mask,
   output logic [WORD_W-1:0][$clog2(WORD_W)-1:0]  rank
);

   localparam int unsigned IW = $clog2(WORD_W);
   localparam int unsigned CW = IW + 1;
   localparam int unsigned LV = $clog2(WORD_W);

   if (RANK_STYLE == RANK_RIPPLE) begin : g_ripple
      // Exclusive count, one adder per position in a chain
      logic [IW-1:0] ex [WORD_W];
      always_comb begin
         ex[0] = '0;
         for (int m = 1; m < WORD_W; m++) begin
            ex[m] = ex[m-1] + IW'(mask[m-1]);
         end
      end
      for (genvar m = 0; m < WORD_W; m++) begin : g_out
         assign rank[m] = ex[m];
      end
   end else begin : g_log
      // Inclusive count by doubling strides, then exclude own bit
      logic [CW-1:0] lvl [LV+1][WORD_W];
      always_comb begin
         for (int m = 0; m < WORD_W; m++) begin
            lvl[0][m] = CW'(mask[m]);
         end
         for (int l = 0; l < LV; l++) begin
            for (int m = 0; m < WORD_W; m++) begin
               if (m >= (1 << l)) begin
                  lvl[l+1][m] = lvl[l][m] + lvl[l][m - (1 << l)];
               end else begin
                  lvl[l+1][m] = lvl[l][m];
               end
            end
         end
      end
      for (genvar m = 0; m < WORD_W; m++) begin : g_out
         logic [CW-1:0] excl;
         assign excl    = lvl[LV][m] - CW'(mask[m]);
         assign rank[m] = excl[IW-1:0];
      end
   end

endmodule

// File: rtl/pdep_scatter.sv
`timescale 1ns/1ps
module pdep_scatter #(
   parameter int unsigned WORD_W = 64
) (
   input  logic [WORD_W-1:0]                     src,
   input  logic [WORD_W-1:0]                     mask,
   input  logic [WORD_W-1:0][$clog2(WORD_W)-1:0] rank,
   output logic [WORD_W-1:0]                     res
);

   for (genvar m = 0; m < WORD_W; m++) begin : g_pos
      assign res[m] = mask[m] & src[rank[m]];
   end

endmodule

// File: rtl/bit_deposit_unit.sv
`timescale 1ns/1ps
module bit_deposit_unit
   import pdep_pkg::*;
#(
   parameter int unsigned WORD_W     = 64,
   parameter int unsigned NARROW_W   = 32,
   parameter int unsigned RANK_STYLE = RANK_LOG,
   parameter int unsigned OUT_REG    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_src,
   input  logic [WORD_W-1:0] in_mask,
   input  logic              in_wide,
   input  logic              in_long_mode,
   input  logic              in_vlen,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_result,
   output logic              out_illegal
);

   localparam int unsigned IW = $clog2(WORD_W);

   // Elaboration-time parameter checks
   if (WORD_W < 2 || (1 << IW) != WORD_W) begin : g_chk_word
      $error("WORD_W must be a power of two of at least 2");
   end
   if (NARROW_W < 1 || NARROW_W > WORD_W) begin : g_chk_narrow
      $error("NARROW_W must lie in 1..WORD_W");
   end
   if (RANK_STYLE > RANK_LOG) begin : g_chk_style
      $error("RANK_STYLE selects an unknown variant");
   end
   if (OUT_REG > 1) begin : g_chk_reg
      $error("OUT_REG must be 0 or 1");
   end

   opctl_t                       ctl;
   logic [WORD_W-1:0]            mask_eff;
   logic [WORD_W-1:0][IW-1:0]    rank;
   logic [WORD_W-1:0]            res_c;
   logic                         legal_go;
   logic                         bad_go;

   pdep_op_ctl u_ctl (
      .wide_req  (in_wide),
      .long_mode (in_long_mode),
      .vlen_bit  (in_vlen),
      .ctl       (ctl)
   );

   pdep_mask_shape #(
      .WORD_W   (WORD_W),
      .NARROW_W (NARROW_W)
   ) u_shape (
      .wide   (ctl.size == SZ_WIDE),
      .mask_i (in_mask),
      .mask_o (mask_eff)
   );

   pdep_rank #(
      .WORD_W     (WORD_W),
      .RANK_STYLE (RANK_STYLE)
   ) u_rank (
      .mask (mask_eff),
      .rank (rank)
   );

   pdep_scatter #(
      .WORD_W (WORD_W)
   ) u_scatter (
      .src  (in_src),
      .mask (mask_eff),
      .rank (rank),
      .res  (res_c)
   );

   assign legal_go = in_valid & ~ctl.illegal;
   assign bad_go   = in_valid &  ctl.illegal;

   if (OUT_REG != 0) begin : g_reg
      logic              vld_q;
      logic              ill_q;
      logic [WORD_W-1:0] res_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            ill_q <= 1'b0;
            res_q <= '0;
         end else begin
            vld_q <= legal_go;
            ill_q <= bad_go;
            if (legal_go) begin
               res_q <= res_c;
            end
         end
      end

      assign out_valid   = vld_q;
      assign out_illegal = ill_q;
      assign out_result  = res_q;
   end else begin : g_comb
      assign out_valid   = legal_go;
      assign out_illegal = bad_go;
      assign out_result  = legal_go ? res_c : '0;
   end

endmodule

// File: rtl/bdu_chk.sv
`timescale 1ns/1ps
module bdu_chk #(
   parameter int unsigned WORD_W   = 64,
   parameter int unsigned NARROW_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [WORD_W-1:0] in_src,
   input logic [WORD_W-1:0] in_mask,
   input logic              in_wide,
   input logic              in_long_mode,
   input logic              in_vlen,
   input logic              out_valid,
   input logic [WORD_W-1:0] out_result,
   input logic              out_illegal
);

   logic              wide_q;
   logic [WORD_W-1:0] narrow_keep;
   logic [WORD_W-1:0] mask_seen;
   logic              legal_in;

   assign wide_q      = in_wide & in_long_mode;
   assign narrow_keep = {{(WORD_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
   assign mask_seen   = wide_q ? in_mask : (in_mask & narrow_keep);
   assign legal_in    = in_valid & ~in_vlen;

   // R7
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      legal_in |=> out_valid && !out_illegal);

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !out_illegal);

   // R6
   illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_vlen |=> out_illegal && !out_valid && $stable(out_result));

   // R8
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_result));

   // R2
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      legal_in |=> (out_result & ~$past(mask_seen)) == '0);

   // R3
   full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      legal_in && wide_q && (&in_mask) |=> out_result == $past(in_src));

   // R4
   narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      legal_in && !wide_q |=> out_result[WORD_W-1:NARROW_W] == '0);

   // R9
   always_comb begin
      if (!rst_n) begin
         reset_state_chk: assert (!out_valid && !out_illegal && out_result == '0);
      end
   end

endmodule

bind bit_deposit_unit bdu_chk #(
   .WORD_W   (WORD_W),
   .NARROW_W (NARROW_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_src       (in_src),
   .in_mask      (in_mask),
   .in_wide      (in_wide),
   .in_long_mode (in_long_mode),
   .in_vlen      (in_vlen),
   .out_valid    (out_valid),
   .out_result   (out_result),
   .out_illegal  (out_illegal)
);

// File: tb/tb_bit_deposit_unit.sv
`timescale 1ns/1ps
module tb_bit_deposit_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_src = '0;
   logic [63:0] in_mask = '0;
   logic        in_wide = 1'b0;
   logic        in_long_mode = 1'b0;
   logic        in_vlen = 1'b0;
   logic        out_valid;
   logic [63:0] out_result;
   logic        out_illegal;

   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;
   logic        exp_v = 1'b0;
   logic        exp_i = 1'b0;
   logic [63:0] exp_r = '0;
   string       prev_tag = "R9";

   always #2 clk = ~clk;   // 4 ns period, 250 MHz

   bit_deposit_unit dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_src       (in_src),
      .in_mask      (in_mask),
      .in_wide      (in_wide),
      .in_long_mode (in_long_mode),
      .in_vlen      (in_vlen),
      .out_valid    (out_valid),
      .out_result   (out_result),
      .out_illegal  (out_illegal)
   );

   // Behavioural deposit model: walk the mask, consume source bits in order
   function automatic logic [63:0] ref_dep(input logic [63:0] s, input logic [63:0] m, input int n);
      logic [63:0] r = '0;
      int k = 0;
      for (int i = 0; i < n; i++) begin
         if (m[i]) begin
            r[i] = s[k];
            k++;
         end
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_outputs();
      chk(out_valid === exp_v, "R7", "out_valid", 64'(out_valid), 64'(exp_v));
      chk(out_illegal === exp_i, "R6", "out_illegal", 64'(out_illegal), 64'(exp_i));
      chk(out_result === exp_r, prev_tag, "out_result", out_result, exp_r);
   endtask

   // One cycle: check what the previous request produced, then drive the next
   task automatic step(input logic v, input logic [63:0] s, input logic [63:0] m,
                       input logic w, input logic lm, input logic vl, input string tag);
      int n;
      @(negedge clk);
      check_outputs();
      in_valid = v; in_src = s; in_mask = m;
      in_wide = w; in_long_mode = lm; in_vlen = vl;
      n = (w && lm) ? 64 : 32;
      exp_v = v && !vl;
      exp_i = v && vl;
      if (v && !vl) exp_r = ref_dep(s, m, n);
      prev_tag = tag;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R7 watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [63:0] s;
      logic [63:0] m;
      // R9: reset state, with inputs active during reset
      in_valid = 1'b1; in_src = '1; in_mask = '1;
      repeat (3) begin
         @(negedge clk);
         chk(!out_valid && !out_illegal && out_result == '0, "R9", "reset state",
             out_result, 64'h0);
      end
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // R10: example mask bits 2,5,7,9, source nibble 1011
      step(1, 64'hFFFF_FFFF_FFFF_FFFB, 64'h0000_0000_0000_02A4, 1, 1, 0, "R10");
      step(0, '1, '1, 1, 1, 0, "R8");
      chk(out_result === 64'h224, "R10", "example constant", out_result, 64'h224);

      // R3: all ones and zero masks at both sizes
      step(1, 64'h0123_4567_89AB_CDEF, '1, 1, 1, 0, "R3");
      step(1, 64'h0123_4567_89AB_CDEF, '0, 1, 1, 0, "R3");
      step(1, 64'hDEAD_BEEF_CAFE_F00D, '1, 0, 0, 0, "R3");
      // R1: single MSB masks and alternating patterns
      step(1, 64'h1, 64'h8000_0000_0000_0000, 1, 1, 0, "R1");
      step(1, 64'h1, 64'h0000_0000_8000_0000, 0, 1, 0, "R1");
      step(1, 64'h5A5A_F0F0_3C3C_9999, 64'hAAAA_AAAA_AAAA_AAAA, 1, 1, 0, "R1");
      step(1, 64'h5A5A_F0F0_3C3C_9999, 64'h5555_5555_5555_5555, 1, 1, 0, "R2");
      // R4: narrow size with junk in upper mask and source halves
      step(1, 64'hFFFF_FFFF_0000_0003, 64'hFFFF_0000_0000_0011, 0, 1, 0, "R4");
      chk(1'b1, "R4", "narrow issued", 64'h0, 64'h0);
      step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, "R4");
      // R5: wide requested outside 64-bit mode is narrowed
      step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF000_0000_0000_000F, 1, 0, 0, "R5");
      step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF000_0000_0000_000F, 1, 1, 0, "R5");
      // R6: illegal requests, including with wide size resolved the same cycle
      step(1, '1, '1, 1, 1, 1, "R6");
      step(1, '1, 64'h00FF, 0, 0, 1, "R6");
      step(0, '0, '0, 0, 0, 0, "R8");
      // R8: idle cycles with moving inputs
      step(0, 64'h1234, '1, 1, 1, 0, "R8");
      step(0, 64'h9876, 64'hF0F0, 0, 1, 1, "R8");
      // alternating sizes back to back with junk upper halves
      for (int i = 0; i < 40; i++) begin
         s = {$urandom, $urandom};
         m = {$urandom, $urandom};
         step(1, s, m, i[0], 1, 0, "R4");
      end
      // random mix of sizes, densities, gaps and illegal requests
      for (int i = 0; i < 600; i++) begin
         s = {$urandom, $urandom};
         m = {$urandom, $urandom};
         case ($urandom_range(0, 3))
            0: m = m & {$urandom, $urandom};
            1: m = m | {$urandom, $urandom};
            default: ;
         endcase
         step($urandom_range(0, 3) != 0, s, m, 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), $urandom_range(0, 15) == 0, "R1");
      end
      step(0, '0, '0, 0, 0, 0, "R8");
      step(0, '0, '0, 0, 0, 0, "R8");
      @(negedge clk);
      check_outputs();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule